// File: doc/BRIEF.md
# Masked Cyclic Sequencer

This block holds a small table of words and walks through it one slot at a time. Each rising edge of the step input moves a position pointer forward. The word at the new slot is merged into a destination register under a bit mask. Destination bits where the mask is 0 keep whatever value they held before. The table has `LAST_IDX + 1` slots. Slot 0 is special: the step input can only reach it in the very first evaluated cycle after reset. Once the pointer passes the last slot, it wraps back to slot 1.

Two other functions use the same pointer. A load function advances the pointer on a rising edge of its enable and writes an input word into the new slot. While that enable stays high, the same slot is rewritten every cycle. A compare function reports, without delay, whether a source word equals the slot under the pointer in every bit the mask selects. The compare function never moves the pointer. A typical use is cycling through a fixed set of output patterns, such as light phases, while other logic records or checks the pattern at each step.

Top module: `mask_cyc_seq`

## Requirements
- R1: A synchronous active-high reset sets the position to 0 and the destination to 0, and arms the first-scan flag. It also sets every table slot i to A5C3h XOR (1111h × i), so slot 0 = A5C3h, slot 1 = B4D2h, slot 2 = 87E1h, slot 3 = 96F0h and slot 4 = E187h.
- R2: On a rising edge of step_i outside the first-scan cycle, the position advances by one and the word at the new position is merged into dest_o. While step_i is held high, nothing further happens.
- R3: A step taken from the last index (4 by default) wraps the position to 1. The position never exceeds the last index.
- R4: If step_i is high in the first evaluated cycle after reset, slot 0 is merged into dest_o and the position stays 0. Apart from that case, the position never returns to 0 and slot 0 is never output.
- R5: A destination update changes only the bits where mask_i is 1. For example, mask 000Fh changes only bits 3:0 and every other bit keeps its old value.
- R6: On a rising edge of load_i, the position advances by one (wrapping from the last index to 1) and load_word_i is written into the new slot. While load_i stays high, the current slot is overwritten with load_word_i every cycle.
- R7: While cmp_i is high, match_o is 1 exactly when (cmp_word_i AND mask_i) equals (current slot AND mask_i). For example, mask 0005h compares only bits 0 and 2.
- R8: match_o is 0 whenever cmp_i is 0. The compare function never changes the position.
- R9: If step_i and load_i both rise in the same cycle, only the step acts. The load word is not written anywhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Step request; acts on its rising edge |
| load_i | input | 1 | Load enable; its rising edge advances the position, its high level writes |
| cmp_i | input | 1 | Compare enable |
| mask_i | input | 16 | Bit mask shared by the output and compare functions |
| load_word_i | input | 16 | Word written by the load function |
| cmp_word_i | input | 16 | Source word for the compare function |
| dest_o | output | 16 | Destination register |
| match_o | output | 1 | Masked compare result |
| pos_o | output | 3 | Current table position |

## Verification
The step function is exercised in several ways: a full mask, a narrow low-nibble mask and a mid-nibble mask, which separates a masked merge from a plain copy. Steps are applied both singly and with the input held, which separates edge detection from level sensing. The pointer is driven through a full lap, so a wrap to slot 1 is distinguished from a wrap to slot 0. Step is applied both in the first cycle after reset and later, which shows whether slot 0 is reachable only in the first scan. Load and compare patterns cover:
- a load held over two cycles with different words, where the later word must win;
- masked compares that differ only in unselected bits, and others that differ in a selected bit;
- a load that collides with a step;
- a second reset, which must restore the original table contents.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    localparam int SEQ_W = 16;

    typedef logic [SEQ_W-1:0] word_t;

    localparam word_t INIT_BASE   = 16'hA5C3;
    localparam word_t INIT_STRIDE = 16'h1111;

    // what the controller does in one cycle
    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_FIRST,
        ACT_STEP,
        ACT_LOAD
    } act_e;

    // successor of a position, wrapping past the last index to 1
    function automatic int next_index(input int p, input int last);
        return (p >= last) ? 1 : p + 1;
    endfunction

    // replace only the bits selected by m
    function automatic word_t masked_merge(input word_t old_w, input word_t new_w, input word_t m);
        return (old_w & ~m) | (new_w & m);
    endfunction

    // reset content of slot i
    function automatic word_t init_word(input int i);
        return INIT_BASE ^ (INIT_STRIDE * word_t'(i));
    endfunction

endpackage

// File: rtl/mcs_edge.sv
module mcs_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    always_comb rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/mcs_table.sv
module mcs_table
    import mcs_pkg::*;
#(
    parameter int LAST_IDX = 4,
    localparam int DEPTH = LAST_IDX + 1,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] rd_a_idx,
    output word_t            rd_a_data,
    input  logic [IDX_W-1:0] rd_b_idx,
    output word_t            rd_b_data
);
    word_t mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[g] <= init_word(g);
            else if (wr_en && (wr_idx == IDX_W'(g)))
                mem[g] <= wr_data;
        end
    end

    always_comb begin
        rd_a_data = mem[rd_a_idx];
        rd_b_data = mem[rd_b_idx];
    end

endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
    import mcs_pkg::*;
#(
    parameter int LAST_IDX = 4,
    localparam int IDX_W = $clog2(LAST_IDX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_rise,
    input  logic             load_rise,
    input  logic             load_lvl,
    input  word_t            mask_i,
    input  word_t            sel_word,
    output logic [IDX_W-1:0] rd_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] pos_o,
    output word_t            dest_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LAST_IDX);

    logic [IDX_W-1:0] pos_q;
    logic [IDX_W-1:0] nxt;
    logic             first_q;
    word_t            dest_q;
    act_e             act;

    always_comb nxt = IDX_W'(next_index(int'(pos_q), LAST_IDX));

    always_comb begin
        if (step_rise)      act = first_q ? ACT_FIRST : ACT_STEP;
        else if (load_rise) act = ACT_LOAD;
        else                act = ACT_IDLE;
    end

    // the word to be shown comes from slot 0 only in the first-scan cycle
    always_comb rd_idx = first_q ? '0 : nxt;

    // a step edge blocks any write in that cycle
    always_comb begin
        wr_en  = load_lvl && !step_rise;
        wr_idx = load_rise ? nxt : pos_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q   <= '0;
            dest_q  <= '0;
            first_q <= 1'b1;
        end else begin
            first_q <= 1'b0;
            case (act)
                ACT_FIRST: dest_q <= masked_merge(dest_q, sel_word, mask_i);
                ACT_STEP: begin
                    pos_q  <= nxt;
                    dest_q <= masked_merge(dest_q, sel_word, mask_i);
                end
                ACT_LOAD: pos_q <= nxt;
                default: ;
            endcase
        end
    end

    always_comb begin
        pos_o  = pos_q;
        dest_o = dest_q;
    end

    assert_step_adv_R2: assert property (@(posedge clk) disable iff (rst)
        (step_rise && !first_q && pos_q != LAST) |=> (pos_q == $past(pos_q) + IDX_W'(1)));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (step_rise && !first_q && pos_q == LAST) |=> (pos_q == IDX_W'(1)));

    assert_range_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (pos_q <= LAST));

    assert_first_stay_R4: assert property (@(posedge clk) disable iff (rst)
        (first_q && step_rise) |=> (pos_q == '0));

    assert_no_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (pos_q != '0) |=> (pos_q != '0));

    assert_mask_keep_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (((dest_q ^ $past(dest_q)) & ~$past(mask_i)) == '0));

    assert_pos_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!step_rise && !load_rise) |=> $stable(pos_q));

endmodule

// File: rtl/mask_cyc_seq.sv
module mask_cyc_seq
    import mcs_pkg::*;
#(
    parameter int LAST_IDX = 4,
    localparam int IDX_W = $clog2(LAST_IDX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    input  logic             load_i,
    input  logic             cmp_i,
    input  word_t            mask_i,
    input  word_t            load_word_i,
    input  word_t            cmp_word_i,
    output word_t            dest_o,
    output logic             match_o,
    output logic [IDX_W-1:0] pos_o
);
    logic [1:0]       rise;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] pos;
    logic             wr_en;
    word_t            sel_word;
    word_t            cur_word;

    mcs_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  ({load_i, step_i}),
        .rise_o (rise)
    );

    mcs_table #(.LAST_IDX(LAST_IDX)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (load_word_i),
        .rd_a_idx  (rd_idx),
        .rd_a_data (sel_word),
        .rd_b_idx  (pos),
        .rd_b_data (cur_word)
    );

    mcs_ctrl #(.LAST_IDX(LAST_IDX)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .step_rise (rise[0]),
        .load_rise (rise[1]),
        .load_lvl  (load_i),
        .mask_i    (mask_i),
        .sel_word  (sel_word),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .pos_o     (pos),
        .dest_o    (dest_o)
    );

    always_comb begin
        match_o = cmp_i && ((cmp_word_i & mask_i) == (cur_word & mask_i));
        pos_o   = pos;
    end

    assert_load_R6: assert property (@(posedge clk) disable iff (rst)
        (rise[1] && !rise[0]) |=> (cur_word == $past(load_word_i)));

    assert_collide_R9: assert property (@(posedge clk) disable iff (rst)
        (rise[1] && rise[0] && pos != IDX_W'(LAST_IDX) && pos != '0) |=> (pos == $past(pos) + IDX_W'(1)));

endmodule

// File: tb/mask_cyc_seq_test.sv
module mask_cyc_seq_test;
    import mcs_pkg::*;

    localparam int LAST = 4;

    typedef struct packed {
        logic       st;
        logic       ld;
        logic       cp;
        logic [15:0] mk;
        logic [15:0] lw;
        logic [15:0] cw;
        logic [2:0] epos;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd0,4'd4}, // R4 no step in first scan
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd1,4'd2}, // R2 first output is slot 1
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd1,4'd2},
        '{1'b1,1'b0,1'b0,16'h000F,16'h0000,16'h0000,3'd2,4'd5}, // R5 low nibble only
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd2,4'd2},
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd3,4'd2},
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd3,4'd2}, // R2 held step
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd3,4'd2},
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd4,4'd2},
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd4,4'd2},
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd1,4'd3}, // R3 wrap to 1
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd1,4'd3},
        '{1'b0,1'b1,1'b0,16'hFFFF,16'h1234,16'h0000,3'd2,4'd6}, // R6 load edge
        '{1'b0,1'b1,1'b0,16'hFFFF,16'h5678,16'h0000,3'd2,4'd6}, // R6 held load
        '{1'b0,1'b0,1'b1,16'hFFFF,16'h0000,16'h5678,3'd2,4'd7}, // R7 full match
        '{1'b0,1'b0,1'b1,16'h0005,16'h0000,16'hFFFA,3'd2,4'd7}, // R7 masked match
        '{1'b0,1'b0,1'b1,16'h0005,16'h0000,16'h0004,3'd2,4'd7}, // R7 masked miss
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h5678,3'd2,4'd8}, // R8 disabled
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd3,4'd2},
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd3,4'd2},
        '{1'b1,1'b1,1'b0,16'hFFFF,16'hAAAA,16'h0000,3'd4,4'd9}, // R9 collision
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd4,4'd9},
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd1,4'd3},
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd1,4'd2},
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd2,4'd6}, // R6 loaded word shown
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd2,4'd2},
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd3,4'd2},
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd3,4'd2},
        '{1'b1,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd4,4'd9}, // R9 slot 4 untouched
        '{1'b0,1'b0,1'b0,16'hFFFF,16'h0000,16'h0000,3'd4,4'd2},
        '{1'b0,1'b1,1'b0,16'hFFFF,16'h0BEE,16'h0000,3'd1,4'd6}, // R6 load wraps to 1
        '{1'b0,1'b0,1'b1,16'hFFFF,16'h0000,16'h0BEE,3'd1,4'd6},
        '{1'b1,1'b0,1'b0,16'h00F0,16'h0000,16'h0000,3'd2,4'd5}  // R5 mid nibble
    };

    logic  clk = 1'b0;
    logic  rst = 1'b1;
    logic  step_i = 1'b0;
    logic  load_i = 1'b0;
    logic  cmp_i = 1'b0;
    word_t mask_i = '0;
    word_t load_word_i = '0;
    word_t cmp_word_i = '0;
    word_t dest_o;
    logic  match_o;
    logic [2:0] pos_o;

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    word_t m_tab [LAST+1];
    int    m_pos;
    word_t m_dest;
    logic  m_first, m_ps, m_pl;

    always #2 clk = ~clk;

    mask_cyc_seq uut (
        .clk(clk), .rst(rst), .step_i(step_i), .load_i(load_i), .cmp_i(cmp_i),
        .mask_i(mask_i), .load_word_i(load_word_i), .cmp_word_i(cmp_word_i),
        .dest_o(dest_o), .match_o(match_o), .pos_o(pos_o)
    );

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_match();
        return cmp_i && ((cmp_word_i & mask_i) == (m_tab[m_pos] & mask_i));
    endfunction

    task automatic model_reset();
        for (int i = 0; i <= LAST; i++) m_tab[i] = 16'hA5C3 ^ (16'h1111 * 16'(i));
        m_pos = 0; m_dest = '0; m_first = 1'b1; m_ps = 1'b0; m_pl = 1'b0;
    endtask

    task automatic model_clock();
        logic rs, rl;
        int nx;
        rs = step_i && !m_ps;
        rl = load_i && !m_pl;
        nx = (m_pos == LAST) ? 1 : m_pos + 1;
        if (rs && m_first) begin
            m_dest = (m_dest & ~mask_i) | (m_tab[0] & mask_i);
        end else if (rs) begin
            m_pos  = nx;
            m_dest = (m_dest & ~mask_i) | (m_tab[nx] & mask_i);
        end else if (load_i) begin
            if (rl) m_pos = nx;
            m_tab[m_pos] = load_word_i;
        end
        m_first = 1'b0;
        m_ps = step_i;
        m_pl = load_i;
    endtask

    task automatic do_reset();
        rst = 1'b1; step_i = 1'b0; load_i = 1'b0; cmp_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    task automatic apply(input logic st, input logic ld, input logic cp, input word_t mk,
                         input word_t lw, input word_t cw, input int epos, input int req);
        step_i = st; load_i = ld; cmp_i = cp;
        mask_i = mk; load_word_i = lw; cmp_word_i = cw;
        @(posedge clk);
        model_clock();
        #1;
        chk(req, "pos", 32'(pos_o), 32'(epos));
        chk(req, "dest", 32'(dest_o), 32'(m_dest));
        chk(req, "match", 32'(match_o), 32'(exp_match()));
        @(negedge clk);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state, before the first evaluated edge
        chk(1, "reset pos", 32'(pos_o), 32'd0);
        chk(1, "reset dest", 32'(dest_o), 32'd0);
        cmp_i = 1'b1; mask_i = 16'hFFFF; cmp_word_i = 16'hA5C3;
        #1 chk(1, "slot0 init match", 32'(match_o), 32'd1);
        cmp_i = 1'b0;
        #1 chk(8, "match with cmp low", 32'(match_o), 32'd0);

        for (int v = 0; v < NV; v++)
            apply(VECS[v].st, VECS[v].ld, VECS[v].cp, VECS[v].mk,
                  VECS[v].lw, VECS[v].cw, int'(VECS[v].epos), int'(VECS[v].req));

        // R4 step high on the first scan shows slot 0 through mask 00FF
        do_reset();
        apply(1'b1, 1'b0, 1'b0, 16'h00FF, '0, '0, 0, 4);
        chk(4, "first scan dest", 32'(dest_o), 32'h00C3);
        apply(1'b1, 1'b0, 1'b0, 16'hFFFF, '0, '0, 0, 2);
        apply(1'b0, 1'b0, 1'b0, 16'hFFFF, '0, '0, 0, 4);
        apply(1'b1, 1'b0, 1'b0, 16'hFFFF, '0, '0, 1, 4);
        chk(4, "after first scan", 32'(dest_o), 32'hB4D2);
        apply(1'b0, 1'b0, 1'b0, 16'hFFFF, '0, '0, 1, 1);
        // R1 slot 2 restored by reset after the earlier load
        apply(1'b1, 1'b0, 1'b0, 16'hFFFF, '0, '0, 2, 1);
        chk(1, "slot2 restored", 32'(dest_o), 32'h87E1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule